// File: doc/BRIEF.md
# Z80 Memory Bank Mapper

This block sits between an 8-bit Z80-style CPU bus and a 512 KB RAM device and a 512 KB flash device. It splits the 64 KB CPU address space into four 16 KB windows. Three of these windows always map to the same physical pages: the lowest window goes to flash page 0, which holds the boot code, and two windows go to RAM pages near the top of the RAM device. The window at 0x8000–0xBFFF is banked. Software loads a page register with one I/O write, and the window then shows any of 32 pages of RAM or of flash. A 64 KB CP/M system uses this to keep its full address space while it reaches the rest of RAM as a RAM disk.

The block samples the bus on a fast system clock. All of its outputs are registered, so each output follows the bus state it sampled one clock earlier. The block drives the physical address lines A14–A18, which are common to both devices, and one active-low chip select for each device. An I/O read of the page port returns the current page register value on a readback data bus, with an enable that is high only during that read. A new page value takes effect only once the write strobe has gone back high, so the OUT instruction that changes the page completes under the old mapping.

Top module: `z80_bank_mapper`

## Requirements
- R1: When `rst` is high at a clock edge, the page register clears to 0 (RAM page 0 in the banked window). After that edge `ram_cs_n` and `rom_cs_n` are 1, `phys_hi` is 0, `rd_data` is 0 and `rd_oe` is 0.
- R2: A memory cycle to 0x0000–0x3FFF selects flash (`rom_cs_n` = 0) with `phys_hi` = 0.
- R3: A memory cycle to 0x4000–0x7FFF selects RAM page 30. A memory cycle to 0xC000–0xFFFF selects RAM page 31.
- R4: A memory cycle to 0x8000–0xBFFF drives `phys_hi` with page register bits 4..0. Page register bit 5 picks the device: 1 selects flash and 0 selects RAM.
- R5: The page register loads from data bits 5..0 on an I/O write (`iorq_n` = 0, `wr_n` = 0, `m1_n` = 1) whose low address byte is 0x38. The upper address byte is not decoded. A write to any other low byte has no effect.
- R6: An I/O cycle with `m1_n` = 0 never loads the page register, even when the low address byte is 0x38.
- R7: The page register keeps its old value while `wr_n` stays low. It takes the written value at the first clock edge that samples `wr_n` high, and the outputs show the new page one clock after that.
- R8: An I/O read (`iorq_n` = 0, `rd_n` = 0, `m1_n` = 1) with low address byte 0x38 sets `rd_oe` = 1 and returns {2'b00, page register} on `rd_data`. Every other cycle gives `rd_oe` = 0 and `rd_data` = 0.
- R9: A chip select goes low only for a cycle that sampled `mreq_n` low, and `ram_cs_n` and `rom_cs_n` are never low at the same time.
- R10: A memory write (`mreq_n` = 0, `iorq_n` = 1) never loads the page register, even when the low address byte is 0x38.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_din | input | 8 | CPU data bus as written by the CPU |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| phys_hi | output | 5 | Physical address lines A14–A18 |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | Flash chip select, active low |
| rd_data | output | 8 | Readback of the page register |
| rd_oe | output | 1 | High while `rd_data` should drive the CPU data bus |

## Verification
The hardest case to reach is the window between the end of a page write and the first access that sees the new page. On a real bus, an I/O cycle and a memory cycle never overlap, so the delay of the page register cannot be seen. The stimulus therefore sends the port write to address 0x8038, which the port decoder accepts because it looks only at the low byte, and holds `mreq_n` low during the write. The banked window then stays visible through the whole write. The bench expects the old page on the chip-select outputs until the cycle after `wr_n` rises, and the new page from then on. Intercept writes with `m1_n` low, memory writes to a low byte of 0x38, and a sweep over all 32 pages of both devices make up the rest of the stimulus.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

  // Number of physical high address bits (A14..A18), i.e. 32 pages of 16 KB.
  localparam int PAGE_W = 5;
  localparam int SEL_W  = PAGE_W + 1;

  // Device selected behind a CPU window.
  typedef enum logic {
    DEV_RAM = 1'b0,
    DEV_ROM = 1'b1
  } bank_dev_e;

  // Page register layout: device bit above the page number.
  typedef struct packed {
    bank_dev_e         dev;
    logic [PAGE_W-1:0] page;
  } bank_sel_t;

endpackage

// File: rtl/io_port_decode.sv
module io_port_decode
  import bank_map_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          PORT_W    = 8,
  parameter logic [7:0]  PORT_ADDR = 8'h38
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  output logic              wr_hit,
  output logic              rd_hit
);

  logic port_match;
  logic io_cycle;

  // Only the low address byte is decoded; an I/O request together with M1
  // is an interrupt acknowledge and never addresses a port.
  assign port_match = (addr[PORT_W-1:0] == PORT_ADDR[PORT_W-1:0]);
  assign io_cycle   = !iorq_n && m1_n;
  assign wr_hit     = io_cycle && port_match && !wr_n;
  assign rd_hit     = io_cycle && port_match && !rd_n;

endmodule

// File: rtl/page_reg.sv
module page_reg
  import bank_map_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic             wr_n,
  input  logic [SEL_W-1:0] din,
  output bank_sel_t        sel_q
);

  logic             armed;
  logic [SEL_W-1:0] cap;

  // A qualified write arms the register and keeps capturing data while the
  // strobe is low; the value commits on the first edge that sees wr_n high.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cap   <= '0;
      sel_q <= '0;
    end else if (armed && wr_n) begin
      sel_q <= bank_sel_t'(cap);
      armed <= 1'b0;
    end else if (wr_hit) begin
      armed <= 1'b1;
      cap   <= din;
    end
  end

  // R7: no change of the mapping while the write strobe is still low.
  p_hold_while_wr_low_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> $stable(sel_q));

  // R7: the captured byte is the one committed after the strobe rises.
  p_commit_after_release_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_n) |=> (sel_q == bank_sel_t'($past(cap)) && !armed));

endmodule

// File: rtl/window_map.sv
module window_map
  import bank_map_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int BOOT_PAGE    = 0,
  parameter int LOW_RAM_PAGE = 30,
  parameter int TOP_RAM_PAGE = 31
) (
  input  logic [ADDR_W-1:0] addr,
  input  bank_sel_t         bank_sel,
  output bank_sel_t         map
);

  localparam int WIN_W = 2;

  logic [WIN_W-1:0] win;
  assign win = addr[ADDR_W-1 -: WIN_W];

  always_comb begin
    unique case (win)
      2'd0: begin
        map.dev  = DEV_ROM;
        map.page = PAGE_W'(BOOT_PAGE);
      end
      2'd1: begin
        map.dev  = DEV_RAM;
        map.page = PAGE_W'(LOW_RAM_PAGE);
      end
      2'd2: begin
        map = bank_sel;
      end
      default: begin
        map.dev  = DEV_RAM;
        map.page = PAGE_W'(TOP_RAM_PAGE);
      end
    endcase
  end

endmodule

// File: rtl/z80_bank_mapper.sv
module z80_bank_mapper
  import bank_map_pkg::*;
#(
  parameter int         ADDR_W       = 16,
  parameter int         DATA_W       = 8,
  parameter logic [7:0] PORT_ADDR    = 8'h38,
  parameter int         BOOT_PAGE    = 0,
  parameter int         LOW_RAM_PAGE = 30,
  parameter int         TOP_RAM_PAGE = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_din,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  output logic [PAGE_W-1:0] phys_hi,
  output logic              ram_cs_n,
  output logic              rom_cs_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);

  logic      wr_hit;
  logic      rd_hit;
  bank_sel_t bank_sel;
  bank_sel_t map;

  io_port_decode #(
    .ADDR_W   (ADDR_W),
    .PORT_W   (8),
    .PORT_ADDR(PORT_ADDR)
  ) u_decode (
    .addr  (cpu_addr),
    .iorq_n(iorq_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .m1_n  (m1_n),
    .wr_hit(wr_hit),
    .rd_hit(rd_hit)
  );

  page_reg u_page (
    .clk   (clk),
    .rst   (rst),
    .wr_hit(wr_hit),
    .wr_n  (wr_n),
    .din   (cpu_din[SEL_W-1:0]),
    .sel_q (bank_sel)
  );

  window_map #(
    .ADDR_W      (ADDR_W),
    .BOOT_PAGE   (BOOT_PAGE),
    .LOW_RAM_PAGE(LOW_RAM_PAGE),
    .TOP_RAM_PAGE(TOP_RAM_PAGE)
  ) u_map (
    .addr    (cpu_addr),
    .bank_sel(bank_sel),
    .map     (map)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_hi  <= '0;
      ram_cs_n <= 1'b1;
      rom_cs_n <= 1'b1;
      rd_data  <= '0;
      rd_oe    <= 1'b0;
    end else begin
      phys_hi  <= map.page;
      ram_cs_n <= !(!mreq_n && map.dev == DEV_RAM);
      rom_cs_n <= !(!mreq_n && map.dev == DEV_ROM);
      rd_oe    <= rd_hit;
      rd_data  <= rd_hit ? DATA_W'(bank_sel) : '0;
    end
  end

  // R9: the two devices never share a cycle.
  p_cs_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(!ram_cs_n && !rom_cs_n));

  // R9: a select follows only a sampled memory request.
  p_cs_needs_mreq_r9: assert property (@(posedge clk) disable iff (rst)
    (!ram_cs_n || !rom_cs_n) |-> $past(!mreq_n));

  // R8: readback only after a real port read, upper bits zero.
  p_readback_r8: assert property (@(posedge clk) disable iff (rst)
    rd_oe |-> ($past(!iorq_n && !rd_n && m1_n) && rd_data[DATA_W-1:SEL_W] == '0));

endmodule

// File: tb/z80_bank_mapper_test.sv
module z80_bank_mapper_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = 16'h0;
  logic [7:0]  cpu_din = 8'h0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [4:0]  phys_hi;
  logic        ram_cs_n, rom_cs_n, rd_oe;
  logic [7:0]  rd_data;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  z80_bank_mapper uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .phys_hi(phys_hi), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  // Behavioural reference: page state and expected registered outputs.
  int   m_page = 0, m_dev = 0, m_cap = 0;
  bit   m_armed = 0, m_valid = 0;
  int   e_phys, e_rd;
  bit   e_ram, e_rom, e_oe;

  always @(posedge clk) begin
    if (rst) begin
      m_page = 0; m_dev = 0; m_armed = 0; m_cap = 0;
      e_phys = 0; e_ram = 1; e_rom = 1; e_rd = 0; e_oe = 0;
    end else begin
      int win, pg, isrom;
      win = cpu_addr / 16384;
      case (win)
        0: begin isrom = 1; pg = 0; end
        1: begin isrom = 0; pg = 30; end
        2: begin isrom = m_dev; pg = m_page; end
        default: begin isrom = 0; pg = 31; end
      endcase
      e_phys = pg;
      e_rom  = !(mreq_n == 0 && isrom == 1);
      e_ram  = !(mreq_n == 0 && isrom == 0);
      if (iorq_n == 0 && rd_n == 0 && m1_n == 1 && cpu_addr[7:0] == 8'h38) begin
        e_oe = 1; e_rd = m_dev * 32 + m_page;
      end else begin
        e_oe = 0; e_rd = 0;
      end
      if (m_armed && wr_n == 1) begin
        m_dev = m_cap / 32; m_page = m_cap % 32; m_armed = 0;
      end else if (iorq_n == 0 && wr_n == 0 && m1_n == 1 && cpu_addr[7:0] == 8'h38) begin
        m_armed = 1; m_cap = cpu_din % 64;
      end
    end
    m_valid = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Every-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (m_valid && !rst) begin
      chk(cur_req, {phys_hi, ram_cs_n, rom_cs_n, rd_oe, rd_data},
          {5'(e_phys), e_ram, e_rom, e_oe, 8'(e_rd)});
    end
  end

  task automatic idle();
    mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1;
  endtask

  // Memory read; one cycle later the selects reflect the sampled address.
  task automatic mem_probe(input logic [15:0] a, input bit rom, input int pg, input string req);
    cur_req = req;
    cpu_addr = a; mreq_n = 0; rd_n = 0;
    @(negedge clk);
    chk(req, {ram_cs_n, rom_cs_n, phys_hi}, {rom, !rom, 5'(pg)});
    idle();
    @(negedge clk);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input bit m1, input string req);
    cur_req = req;
    cpu_addr = a; cpu_din = d; iorq_n = 0; wr_n = 0; m1_n = m1;
    @(negedge clk);
    @(negedge clk);
    idle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic io_read(input logic [15:0] a, input bit m1, input bit oe, input logic [7:0] d,
                         input string req);
    cur_req = req;
    cpu_addr = a; iorq_n = 0; rd_n = 0; m1_n = m1;
    @(negedge clk);
    chk(req, {rd_oe, rd_data}, {oe, d});
    idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state right after reset
    chk("R1", {phys_hi, ram_cs_n, rom_cs_n, rd_oe, rd_data}, {5'd0, 1'b1, 1'b1, 1'b0, 8'h00});
    rst = 0;
    @(negedge clk);
    mem_probe(16'h8000, 0, 0, "R1");
    mem_probe(16'h0123, 1, 0, "R2");
    mem_probe(16'h3FFF, 1, 0, "R2");
    mem_probe(16'h4000, 0, 30, "R3");
    mem_probe(16'hC000, 0, 31, "R3");
    mem_probe(16'hFFFF, 0, 31, "R3");

    io_write(16'h0038, 8'h05, 1, "R4");
    mem_probe(16'h8000, 0, 5, "R4");
    io_write(16'h0038, 8'hFF, 1, "R4"); // bits 7..6 dropped
    mem_probe(16'hBFFF, 1, 31, "R4");
    io_read(16'h0038, 1, 1, 8'h3F, "R8");

    io_write(16'h1238, 8'h07, 1, "R5");
    mem_probe(16'h8000, 0, 7, "R5");
    io_write(16'h0039, 8'h02, 1, "R5");
    mem_probe(16'h8000, 0, 7, "R5");
    io_write(16'h0038, 8'h24, 0, "R6");
    mem_probe(16'h8000, 0, 7, "R6");
    io_read(16'h0038, 0, 0, 8'h00, "R6");

    // R10: memory write to low byte 0x38 leaves the page alone
    cur_req = "R10";
    cpu_addr = 16'h0038; cpu_din = 8'h09; mreq_n = 0; wr_n = 0;
    @(negedge clk); @(negedge clk);
    idle(); @(negedge clk); @(negedge clk);
    mem_probe(16'h8000, 0, 7, "R10");

    io_read(16'h0039, 1, 0, 8'h00, "R8");
    io_read(16'h0038, 1, 1, 8'h07, "R8");

    // R9: no select without a memory request
    cur_req = "R9";
    cpu_addr = 16'h8000; rd_n = 0;
    @(negedge clk);
    chk("R9", {ram_cs_n, rom_cs_n}, 2'b11);
    idle(); @(negedge clk);

    // R7: write to port via 0x8038 with the banked window held visible
    cur_req = "R7";
    cpu_addr = 16'h8038; mreq_n = 0; cpu_din = 8'h2A; iorq_n = 0; wr_n = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R7", {rom_cs_n, phys_hi}, {1'b1, 5'd7});
    wr_n = 1; iorq_n = 1;
    @(negedge clk);
    chk("R7", {rom_cs_n, phys_hi}, {1'b1, 5'd7});
    @(negedge clk);
    chk("R7", {rom_cs_n, phys_hi}, {1'b0, 5'd10});
    idle(); @(negedge clk);

    // R4: sweep all pages of both devices
    for (int i = 0; i < 64; i++) begin
      io_write(16'h0038, 8'(i), 1, "R4");
      mem_probe(16'h9234, i >= 32, i % 32, "R4");
    end

    // R1: reset again clears the page
    cur_req = "R1";
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    mem_probe(16'h8000, 0, 0, "R1");
    io_read(16'h0038, 1, 1, 8'h00, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule